// File: doc/BRIEF.md
# Masked Fixed-Priority Interrupt Controller

This block gathers interrupt requests from four devices into a request register. Each device sets its own bit. A mask written by software gates every bit on its own. A fixed-priority encoder picks the lowest-numbered unmasked pending source and turns its index into a 2-bit code. The code forms the low bits of an 8-bit vector address, and the upper bits of that address are zero.

A global enable flag decides whether pending unmasked work raises the interrupt line to the processor. The processor answers with an acknowledge. While the acknowledge is high, the block drives the vector address. On the clock edge that ends the acknowledge cycle, it clears the request bit of the source it vectored.

Mask and enable are written through a one-word register port. A select input chooses the target of each write.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request register, the mask and the enable flag are all zero, so `irq` is 0 and `vec` is 0.
- R2: A high `dev_req[i]` at a rising edge sets request bit i at that edge. The bit stays set until an acknowledge clears it.
- R3: Mask bit i = 1 lets request bit i through and mask bit i = 0 blocks it. A blocked pending bit raises no interrupt. It is not lost, and it takes effect once it is unmasked. A write with `cfg_sel` = 0 loads the mask from `cfg_wdata`.
- R4: Among the unmasked pending bits, the lowest index wins. The code equals that index: source 0 gives 00, source 1 gives 01, source 2 gives 10 and source 3 gives 11.
- R5: While `ack` is 1 and at least one unmasked bit is pending, `vec` equals the winning code in bits 1:0 with bits 7:2 zero. Otherwise `vec` is all zero.
- R6: `irq` is 1 exactly when the enable flag is 1 and at least one unmasked bit is pending. A write with `cfg_sel` = 1 loads the enable flag from `cfg_wdata[0]`.
- R7: An acknowledge with an unmasked bit pending clears only the winning request bit at the rising edge that ends the acknowledge cycle. All other request bits are kept.
- R8: If a device request arrives in the same cycle as the clear of its own bit, the request wins and the bit stays set.
- R9: An acknowledge with no unmasked pending bit clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 4 | Per-device request pulses or levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 selects the mask, 1 selects the enable flag |
| cfg_wdata | input | 4 | Write data: the mask value, or the enable flag in bit 0 |
| ack | input | 1 | Interrupt acknowledge from the processor |
| irq | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Vector address, driven during acknowledge |

## Verification
The hardest case to reach is an acknowledge clearing a bit on the same edge at which that device requests again (R8). The outcome is only visible on a later acknowledge, which must still vector to the same source.

Directed sequences set up exactly this collision. They also cover an acknowledge on an empty or fully masked register, and masked sources that later become unmasked.

Random cycles then mix requests, mask and enable writes, and acknowledges. These cycles produce many more collisions and priority ties, and each one is compared against a model in the bench.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    CFG_MASK   = 1'b0,
    CFG_ENABLE = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  // set has priority over clear (R8)
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> pend_o[i]);
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  cfg_sel_e         sel_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             ien_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '0;
      ien_o  <= 1'b0;
    end else if (we_i) begin
      if (sel_i == CFG_MASK) mask_o <= wdata_i;
      else                   ien_o  <= wdata_i[0];
    end
  end

  a_r6_ien_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == CFG_ENABLE) |=> ien_o == $past(wdata_i[0]));
  a_r3_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && sel_i == CFG_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC  = 4,
  parameter int CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]  req_i,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);
  // lowest index has highest priority (R4)
  function automatic logic [CODE_W-1:0] lowest_set(input logic [N_SRC-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (v[i]) c = CODE_W'(i);
    return c;
  endfunction

  assign code_o = lowest_set(req_i);
  assign any_o  = |req_i;

  always_comb begin
    if (any_o) a_r4_winner_set: assert (req_i[code_o]);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int VEC_W  = 8,
  localparam int CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] dev_req,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [N_SRC-1:0] cfg_wdata,
  input  logic             ack,
  output logic             irq,
  output logic [VEC_W-1:0] vec
);
  logic [N_SRC-1:0]  pend, mask, unmasked, clr;
  logic              ien, ist, take;
  logic [CODE_W-1:0] code;

  irq_pend_reg #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(dev_req), .clr_i(clr), .pend_o(pend));

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel_e'(cfg_sel)),
    .wdata_i(cfg_wdata), .mask_o(mask), .ien_o(ien));

  assign unmasked = pend & mask;

  irq_prio_enc #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_enc (
    .req_i(unmasked), .code_o(code), .any_o(ist));

  // acknowledge event that vectors a source
  assign take = ack && ist;
  assign clr  = take ? (N_SRC'(1) << code) : '0;
  assign irq  = ien && ist;
  assign vec  = take ? VEC_W'(code) : '0;

  a_r6_irq_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && |(pend & mask)));
  a_r6_irq_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && |(pend & mask)) |-> irq);
  a_r5_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> vec == '0);
  a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
  a_r9_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (pend & mask) == '0) |=> pend == ($past(pend) | $past(dev_req)));
  a_r4_top_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && mask[0] && ack) |-> vec == '0);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/100ps
module prio_irq_ctrl_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] dev_req = 0;
  logic       cfg_we = 0, cfg_sel = 0, ack = 0;
  logic [3:0] cfg_wdata = 0;
  logic       irq;
  logic [7:0] vec;

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_pend = 0, m_mask = 0;
  logic       m_ien = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ack(ack), .irq(irq), .vec(vec));

  // priority by explicit case table: 0 highest
  function automatic logic [1:0] exp_code(input logic [3:0] u);
    casez (u)
      4'b???1: return 2'd0;
      4'b??10: return 2'd1;
      4'b?100: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] rq, input logic we, input logic sel,
                      input logic [3:0] wd, input logic ak, input string tag);
    logic [3:0] u, clr, nxt;
    logic       ist;
    logic [1:0] c;
    dev_req = rq; cfg_we = we; cfg_sel = sel; cfg_wdata = wd; ack = ak;
    #1;
    u = m_pend & m_mask; ist = |u; c = exp_code(u);
    check("R6 irq", {7'd0, irq}, {7'd0, m_ien & ist});
    check(tag, vec, (ak && ist) ? {6'd0, c} : 8'd0);
    clr = (ak && ist) ? (4'b1 << c) : 4'b0;
    nxt = (m_pend & ~clr) | rq;
    @(posedge clk);
    m_pend = nxt;
    if (we) begin
      if (sel) m_ien = wd[0];
      else     m_mask = wd;
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    check("R1 irq after reset", {7'd0, irq}, 8'd0);
    rst_n = 1;
    step(4'h0, 0, 0, 4'h0, 1, "R1 vec after reset");
    // masked pending: no irq, then unmask
    step(4'hA, 1, 1, 4'h1, 0, "R3 enable");
    step(4'h0, 0, 0, 4'h0, 1, "R3 masked ack");
    step(4'h0, 1, 0, 4'hF, 0, "R3 unmask");
    step(4'h0, 0, 0, 4'h0, 1, "R4 vector src1");
    step(4'h0, 0, 0, 4'h0, 1, "R7 vector src3");
    step(4'h0, 0, 0, 4'h0, 1, "R9 empty ack");
    // collision: request while bit cleared
    step(4'h4, 0, 0, 4'h0, 0, "R2 set src2");
    step(4'h4, 0, 0, 4'h0, 1, "R8 clear and set");
    step(4'h0, 0, 0, 4'h0, 1, "R8 src2 kept");
    step(4'hF, 0, 0, 4'h0, 0, "R2 all set");
    for (int k = 0; k < 4; k++) step(4'h0, 0, 0, 4'h0, 1, "R4 order");
    step(4'h0, 0, 0, 4'h0, 1, "R9 empty again");
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] rq, wd;
      logic we, sel, ak;
      rq  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      we  = ($urandom % 8) == 0;
      sel = ($urandom % 3) == 0;
      wd  = 4'($urandom);
      ak  = ($urandom % 3) == 0;
      step(rq, we, sel, wd, ak, "R5 R7 random vec");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule